// File: doc/BRIEF.md
# Reset-Triggered Delayed Pulse Generator

This block produces a timed train of logic-level pulses that follows a rising edge on an external reset line. The host first loads an offset, a pulse width, an inter-pulse gap and a repeat count on the configuration inputs, then arms the block. Once armed, the block waits for the reset line to rise. It then waits for the programmed offset and emits the programmed number of pulses. The offset counts whole clock cycles, so a host can move the pulse one cycle per attempt. Each arming gives at most one sequence, and the host must arm again before the next attempt.

The reset line is asynchronous. It passes through a two-flop synchronizer and then a rising-edge detector. The configuration is captured when the block is armed, so the host may prepare the next settings while a sequence runs. Three status outputs report the state: armed, busy and done. A disarm input abandons the current sequence from any state.

The control is one state machine with five states:
- IDLE
- ARMED
- DELAY (counting the offset)
- PULSE (output high)
- GAP (low time between pulses)

Its transitions are:
- IDLE to ARMED on arm.
- ARMED to DELAY on a detected edge with a nonzero offset.
- ARMED to PULSE on a detected edge with a zero offset.
- ARMED to IDLE, with done set, on a detected edge when the width or the repeat count is zero.
- DELAY to PULSE when the offset count expires.
- PULSE to GAP when the width expires and pulses remain.
- PULSE to IDLE, with done set, when the width expires on the last pulse.
- GAP to PULSE when the gap expires.
- Any state except IDLE to IDLE on disarm.

Top module: `trig_pulse_gen`

## Requirements
- R1: During reset and after it is released, with arm_i and line_i low, pulse_o, armed_o, busy_o and done_o are all 0.
- R2: arm_i in IDLE with disarm_i low sets armed_o at the next clock edge and clears done_o. arm_i is ignored while the block is armed or busy. disarm_i takes priority over arm_i.
- R3: While armed, a rising edge on line_i that is first sampled high at clock edge k sets busy_o after edge k+2 and clears armed_o. Rising edges while idle or busy are ignored, so one arming yields at most one sequence.
- R4: The first pulse rises after edge k+2+OFFSET, where OFFSET is the latched cfg_offset_i value. An offset of 0 gives the minimum latency.
- R5: Each pulse holds pulse_o high for exactly WIDTH consecutive cycles.
- R6: Exactly REPEAT pulses are emitted. Consecutive pulses are separated by max(GAP,1) cycles with pulse_o low.
- R7: The configuration inputs are sampled only when arm_i is accepted. Changing them after arming has no effect on the running or pending sequence.
- R8: A latched WIDTH of 0 or REPEAT of 0 produces no pulse. After edge k+2 the block is idle with done_o high and busy_o never set.
- R9: The cycle after the last pulse ends, busy_o is 0 and done_o is 1. done_o stays 1 until the next accepted arm.
- R10: disarm_i in any state other than IDLE makes pulse_o, armed_o and busy_o 0 after the next clock edge, and does not set done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Latch configuration and arm |
| disarm_i | input | 1 | Abort pending or active sequence |
| cfg_offset_i | input | OFS_W | Cycles from detected edge to first pulse |
| cfg_width_i | input | WID_W | Pulse high time in cycles |
| cfg_gap_i | input | GAP_W | Low time between pulses (0 treated as 1) |
| cfg_repeat_i | input | REP_W | Number of pulses |
| line_i | input | 1 | External reset line, asynchronous |
| pulse_o | output | 1 | Generated pulse |
| armed_o | output | 1 | Waiting for a rising edge |
| busy_o | output | 1 | Offset, pulse or gap in progress |
| done_o | output | 1 | Last armed sequence completed |

## Verification
The assertions assume that line_i is low while rst_n is low, so that the edge detector does not start from an unknown level. They also assume that arm_i and disarm_i are single-cycle pulses driven synchronously with the clock. The bench changes every input on the falling clock edge. It returns line_i low and lets it settle for several cycles between attempts. It keeps the random offsets, widths, gaps and repeat counts small enough that every expected trace fits inside the observation window.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DELAY = 3'd2,
        ST_PULSE = 3'd3,
        ST_GAP   = 3'd4
    } tpg_state_e;
endpackage

// File: rtl/tpg_line_sync.sv
module tpg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R3: an edge is reported for a single cycle only
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tpg_down_cnt.sv
module tpg_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - W'(1);
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);

    // R6: counters never wrap below zero
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import tpg_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int WID_W     = 8,
    parameter int GAP_W     = 8,
    parameter int REP_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic [OFS_W-1:0] cfg_offset_i,
    input  logic [WID_W-1:0] cfg_width_i,
    input  logic [GAP_W-1:0] cfg_gap_i,
    input  logic [REP_W-1:0] cfg_repeat_i,
    input  logic             line_i,
    output logic             pulse_o,
    output logic             armed_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int MAX_WG = (WID_W > GAP_W) ? WID_W : GAP_W;
    localparam int CNT_W  = (OFS_W > MAX_WG) ? OFS_W : MAX_WG;

    tpg_state_e state_q, state_d;

    logic [OFS_W-1:0] ofs_q;
    logic [WID_W-1:0] wid_q;
    logic [GAP_W-1:0] gap_q;
    logic [REP_W-1:0] rep_q;
    logic             done_q;

    logic             rise;
    logic             ph_load, ph_dec, ph_zero;
    logic [CNT_W-1:0] ph_val, ph_cnt;
    logic             rp_load, rp_dec, rp_zero;
    logic [REP_W-1:0] rp_cnt;
    logic             latch_cfg, set_done, clr_done;
    logic [CNT_W-1:0] wid_m1, ofs_m1, gap_m1;

    tpg_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .rise_o (rise)
    );

    tpg_down_cnt #(.W(CNT_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ph_load),
        .load_val_i (ph_val),
        .dec_i      (ph_dec),
        .count_o    (ph_cnt),
        .zero_o     (ph_zero)
    );

    tpg_down_cnt #(.W(REP_W)) u_repeat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rp_load),
        .load_val_i (rep_q),
        .dec_i      (rp_dec),
        .count_o    (rp_cnt),
        .zero_o     (rp_zero)
    );

    assign wid_m1 = CNT_W'(wid_q) - CNT_W'(1);
    assign ofs_m1 = CNT_W'(ofs_q) - CNT_W'(1);
    assign gap_m1 = (gap_q == '0) ? '0 : (CNT_W'(gap_q) - CNT_W'(1));

    // configuration captured at arm time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
            wid_q <= '0;
            gap_q <= '0;
            rep_q <= '0;
        end else if (latch_cfg) begin
            ofs_q <= cfg_offset_i;
            wid_q <= cfg_width_i;
            gap_q <= cfg_gap_i;
            rep_q <= cfg_repeat_i;
        end
    end

    // state register and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr_done)      done_q <= 1'b0;
            else if (set_done) done_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        ph_load   = 1'b0;
        ph_val    = '0;
        ph_dec    = 1'b0;
        rp_load   = 1'b0;
        rp_dec    = 1'b0;
        latch_cfg = 1'b0;
        set_done  = 1'b0;
        clr_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i && !disarm_i) begin
                    state_d   = ST_ARMED;
                    latch_cfg = 1'b1;
                    clr_done  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (disarm_i) begin
                    state_d = ST_IDLE;
                end else if (rise) begin
                    if (wid_q == '0 || rep_q == '0) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else begin
                        rp_load = 1'b1;
                        ph_load = 1'b1;
                        if (ofs_q == '0) begin
                            state_d = ST_PULSE;
                            ph_val  = wid_m1;
                        end else begin
                            state_d = ST_DELAY;
                            ph_val  = ofs_m1;
                        end
                    end
                end
            end
            ST_DELAY: begin
                if (disarm_i) begin
                    state_d = ST_IDLE;
                end else if (ph_zero) begin
                    state_d = ST_PULSE;
                    ph_load = 1'b1;
                    ph_val  = wid_m1;
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_PULSE: begin
                if (disarm_i) begin
                    state_d = ST_IDLE;
                end else if (ph_zero) begin
                    rp_dec = 1'b1;
                    if (rp_cnt == REP_W'(1)) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else begin
                        state_d = ST_GAP;
                        ph_load = 1'b1;
                        ph_val  = gap_m1;
                    end
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_GAP: begin
                if (disarm_i) begin
                    state_d = ST_IDLE;
                end else if (ph_zero) begin
                    state_d = ST_PULSE;
                    ph_load = 1'b1;
                    ph_val  = wid_m1;
                end else begin
                    ph_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        pulse_o = 1'b0;
        armed_o = 1'b0;
        busy_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: armed_o = 1'b1;
            ST_DELAY: busy_o  = 1'b1;
            ST_PULSE: begin
                busy_o  = 1'b1;
                pulse_o = 1'b1;
            end
            ST_GAP:   busy_o  = 1'b1;
            default:  ;
        endcase
        done_o = done_q;
    end

    // R10: disarm clears everything by the next edge
    assert_disarm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_i && (armed_o || busy_o)) |=> (!pulse_o && !armed_o && !busy_o && !done_o));

    // R3: a sequence only starts from the armed state
    assert_busy_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(armed_o));

    // R9: done is exclusive with armed and busy
    assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !armed_o));

    // R5: pulse only while a sequence is active
    assert_pulse_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> busy_o);

    // R2: arming is only accepted from idle
    assert_arm_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> ($past(arm_i) && !$past(busy_o) && !$past(disarm_i)));

    // R7: latched settings hold while busy
    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(ofs_q) && $stable(wid_q) && $stable(rep_q))));
endmodule

// File: tb/trig_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module trig_pulse_gen_tb_top;
    localparam int LEN = 170;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0, disarm_i = 1'b0, line_i = 1'b0;
    logic [15:0] cfg_offset_i = '0;
    logic [7:0]  cfg_width_i = '0, cfg_gap_i = '0, cfg_repeat_i = '0;
    logic        pulse_o, armed_o, busy_o, done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    trig_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
        .cfg_offset_i(cfg_offset_i), .cfg_width_i(cfg_width_i),
        .cfg_gap_i(cfg_gap_i), .cfg_repeat_i(cfg_repeat_i), .line_i(line_i),
        .pulse_o(pulse_o), .armed_o(armed_o), .busy_o(busy_o), .done_o(done_o)
    );

    // expected {armed,busy,pulse,done} after edge k+i
    function automatic logic [3:0] exp_at(int i, int off, int w, int g, int r);
        int t, ge, per, total;
        if (i < 2) return 4'b1000;
        if (w == 0 || r == 0) return 4'b0001;
        t = i - 2;
        if (t < off) return 4'b0100;
        t -= off;
        ge = (g == 0) ? 1 : g;
        per = w + ge;
        total = r * w + (r - 1) * ge;
        if (t >= total) return 4'b0001;
        return ((t % per) < w) ? 4'b0110 : 4'b0100;
    endfunction

    function automatic int end_idx(int off, int w, int g, int r);
        int ge;
        if (w == 0 || r == 0) return 2;
        ge = (g == 0) ? 1 : g;
        return 2 + off + r * w + (r - 1) * ge;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_arm(int off, int w, int g, int r);
        @(negedge clk);
        cfg_offset_i = 16'(off); cfg_width_i = 8'(w);
        cfg_gap_i = 8'(g); cfg_repeat_i = 8'(r);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        // R7: scramble inputs after arming
        cfg_offset_i = 16'($urandom_range(0, 60));
        cfg_width_i = 8'($urandom_range(0, 9));
        cfg_gap_i = 8'($urandom_range(0, 6));
        cfg_repeat_i = 8'($urandom_range(0, 6));
    endtask

    task automatic run_trial(int off, int w, int g, int r, bit poke_arm);
        int bad = 0;
        int e;
        logic [3:0] act, exp, first_a, first_e;
        string tag;
        first_a = '0; first_e = '0;
        e = end_idx(off, w, g, r);
        do_arm(off, w, g, r);
        check("R2 armed after arm", {armed_o, busy_o, pulse_o, done_o}, 4'b1000);
        line_i = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            @(posedge clk);
            @(negedge clk);
            arm_i = 1'b0;
            act = {armed_o, busy_o, pulse_o, done_o};
            exp = exp_at(i, off, w, g, r);
            if (act !== exp) begin
                if (bad == 0) begin first_a = act; first_e = exp; end
                bad++;
            end
            if (poke_arm && i == 4 && e >= 7) arm_i = 1'b1; // R2 ignored while busy
        end
        if (w == 0 || r == 0) tag = "R8 zero width/repeat trace";
        else tag = "R3 R4 R5 R6 R7 R9 trace";
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s off=%0d w=%0d g=%0d r=%0d: actual %b expected %b",
                     tag, off, w, g, r, first_a, first_e);
        end
        line_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 in reset", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);

        // R3: edge while idle is ignored
        line_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 edge in idle ignored", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);
        line_i = 1'b0;
        repeat (4) @(negedge clk);

        // directed corners
        run_trial(0, 1, 0, 1, 0);
        run_trial(0, 3, 0, 3, 1);
        run_trial(5, 2, 4, 2, 1);
        run_trial(7, 0, 2, 3, 0);
        run_trial(3, 4, 1, 0, 0);
        run_trial(1, 1, 1, 5, 1);

        // R3: no second sequence without rearming; R9 done held
        line_i = 1'b1;
        repeat (12) @(negedge clk);
        check("R3 R9 no refire without arm", {armed_o, busy_o, pulse_o, done_o}, 4'b0001);
        line_i = 1'b0;
        repeat (4) @(negedge clk);

        // R10: disarm during pulse
        do_arm(2, 20, 1, 1);
        line_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 pulse running before disarm", {armed_o, busy_o, pulse_o, done_o}, 4'b0110);
        disarm_i = 1'b1;
        @(negedge clk);
        disarm_i = 1'b0;
        check("R10 disarm during pulse", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);
        line_i = 1'b0;
        repeat (4) @(negedge clk);

        // R10: disarm while armed, then edge ignored
        do_arm(0, 2, 1, 1);
        disarm_i = 1'b1;
        @(negedge clk);
        disarm_i = 1'b0;
        check("R10 disarm while armed", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);
        line_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 edge after disarm ignored", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);
        line_i = 1'b0;
        repeat (4) @(negedge clk);

        // R2: disarm wins over simultaneous arm
        @(negedge clk);
        arm_i = 1'b1; disarm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0; disarm_i = 1'b0;
        check("R2 disarm beats arm", {armed_o, busy_o, pulse_o, done_o}, 4'b0000);

        // random trials
        for (int n = 0; n < 40; n++) begin
            run_trial(int'($urandom_range(0, 40)), int'($urandom_range(0, 8)),
                      int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                      bit'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule